// File: doc/BRIEF.md
# Endpoint Transmit Buffer Loader

This block is the processor-side write path into the transmit packet buffers of a USB device controller. Software reaches it through three write-only registers: a control register that names a logical endpoint and arms loading, a length register that holds the packet's byte count, and a 32-bit data register. Each data word lands in the next word slot of the selected endpoint's buffer, and the block counts down the bytes still owed. When the count runs out, the block raises that endpoint's packet-ready flag for the serial interface engine, stores the byte count, and disarms itself.

The serial engine reads packets one byte at a time by endpoint and byte index, reads the stored byte count of the same endpoint, and hands a packet back with an acknowledge strobe that drops its ready flag. Data that is too long for one packet is cut by software into full-size packets and one short packet. For 130 bytes at 64 bytes per packet, that gives 64, 64 and 2 bytes. The block handles each of these as an independent packet.

A small state machine controls loading. It has three states. ST_IDLE means not armed. ST_ARMED means an endpoint is selected and no length has been accepted yet. ST_LOAD means words are being taken.

The transitions are:
- arm (ST_IDLE to ST_ARMED): a control write with the enable bit set.
- reselect (ST_ARMED or ST_LOAD to ST_ARMED): a control write with the enable bit set.
- disarm (ST_ARMED or ST_LOAD to ST_IDLE): a control write with the enable bit clear.
- start (ST_ARMED or ST_LOAD to ST_LOAD): a non-zero length that is accepted.
- empty (to ST_IDLE): an accepted zero length.
- finish (ST_LOAD to ST_IDLE): the last data word.

Misuse never changes the state. Misuse means a data write outside ST_LOAD, a length write in ST_IDLE, or a length above the limit. Each of these raises a sticky error instead.

Top module: `ep_tx_loader`

## Requirements
- R1: A register write (`reg_wr`=1) with `reg_sel`=0 is a control write: bit 0 is the enable, bits EP_W:1 the endpoint. Enable 1 selects that endpoint and arms loading. Enable 0 disarms. A control write never sets a ready flag. `reg_sel`=3 has no effect.
- R2: A write with `reg_sel`=1 carries the length in bits 9:0. It is accepted only while armed and only if it is at most MAX_PKT_BYTES (64). An accepted length clears the selected endpoint's ready flag and starts a new packet at word slot 0. A later accepted length restarts the packet.
- R3: A write with `reg_sel`=2 while loading stores the word in the next slot. The bytes are little-endian: byte index 4k+j of the endpoint buffer equals bits 8j+7:8j of the k-th word written, so bits 7:0 of the first word are byte 0.
- R4: Each stored word lowers the remaining count by 4. After the word that brings it to zero or below, the endpoint's ready flag reads 1, its byte count equals the programmed length, and loading is disarmed. For example, 5 bytes take 2 words and 2 bytes take 1 word.
- R5: An accepted length of 0 sets the ready flag at once, with a byte count of 0, and disarms.
- R6: A data write while not loading is ignored: no buffer byte, flag or count changes. It sets `load_err`, which stays 1 until reset.
- R7: A length that is too large, or a length written while not armed, is ignored and sets `load_err`. Ready flags and counts are unchanged, and an armed selection stays armed.
- R8: `sie_ack` clears the ready flag of `sie_ack_ep`. If the finishing word of the same endpoint arrives in the same cycle, the flag ends up set.
- R9: A control write during loading abandons the packet: no ready flag is raised for it.
- R10: After reset all ready flags, byte counts and `load_err` are 0.
- R11: Completing, restarting or acknowledging one endpoint leaves the flags and counts of all other endpoints unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 length, 2 data |
| reg_wdata | input | 32 | Register write data |
| sie_ack | input | 1 | Serial engine releases a packet |
| sie_ack_ep | input | EP_W | Endpoint being released |
| sie_rd_ep | input | EP_W | Endpoint read by the serial engine |
| sie_rd_idx | input | BADDR_W | Byte index read by the serial engine |
| pkt_ready | output | NUM_EP | Per-endpoint packet-ready flags |
| sie_byte_count | output | LEN_W | Stored byte count of `sie_rd_ep` |
| sie_rd_byte | output | 8 | Byte at `sie_rd_idx` of `sie_rd_ep` |
| load_err | output | 1 | Sticky misuse flag |

## Verification
Two events can meet in one cycle: the finishing data word, which sets an endpoint's ready flag, and the serial engine's acknowledge, which clears it. The bench drives both in the same cycle, for the same endpoint and for different ones. It expects set to win on a shared endpoint and both effects to apply otherwise. Random traffic also mixes acknowledges with length restarts, where both events clear the flag.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOAD  = 2'd2
    } ldr_state_e;

    localparam int WORD_BYTES = 4;

endpackage

// File: rtl/ldr_ctrl_fsm.sv
module ldr_ctrl_fsm
    import ldr_pkg::*;
#(
    parameter int NUM_EP        = 4,
    parameter int MAX_PKT_BYTES = 64,
    parameter int LEN_W         = 10,
    localparam int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int WORDS   = MAX_PKT_BYTES / WORD_BYTES,
    localparam int WADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    output logic               mem_we,
    output logic [EP_W-1:0]    cur_ep,
    output logic [WADDR_W-1:0] cur_widx,
    output logic               done_set,
    output logic [LEN_W-1:0]   done_len,
    output logic               start_clr,
    output logic               err_flag
);

    ldr_state_e state_q, state_d;

    logic [EP_W-1:0]         ep_q;
    logic [LEN_W-1:0]        len_q;
    logic signed [LEN_W:0]   rem_q;
    logic signed [LEN_W:0]   rem_after;
    logic [WADDR_W-1:0]      widx_q;
    logic                    err_q;

    logic is_ctrl, is_len, is_data;
    logic ctrl_en;
    logic [EP_W-1:0]  ctrl_ep;
    logic [LEN_W-1:0] len_val;
    logic len_ok, len_zero;
    logic ep_take, len_take, word_take, err_set;

    assign is_ctrl  = reg_wr && (reg_sel == SEL_CTRL);
    assign is_len   = reg_wr && (reg_sel == SEL_LEN);
    assign is_data  = reg_wr && (reg_sel == SEL_DATA);
    assign ctrl_en  = reg_wdata[0];
    assign ctrl_ep  = reg_wdata[EP_W:1];
    assign len_val  = reg_wdata[LEN_W-1:0];
    assign len_ok   = ({1'b0, len_val} <= (LEN_W+1)'(MAX_PKT_BYTES));
    assign len_zero = (len_val == '0);
    assign rem_after = rem_q - (LEN_W+1)'(WORD_BYTES);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        mem_we    = 1'b0;
        done_set  = 1'b0;
        done_len  = len_q;
        start_clr = 1'b0;
        ep_take   = 1'b0;
        len_take  = 1'b0;
        word_take = 1'b0;
        err_set   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (is_ctrl && ctrl_en) begin
                    state_d = ST_ARMED;            // arm
                    ep_take = 1'b1;
                end else if (is_len || is_data) begin
                    err_set = 1'b1;
                end
            end
            ST_ARMED, ST_LOAD: begin
                if (is_ctrl) begin
                    state_d = ctrl_en ? ST_ARMED : ST_IDLE;  // reselect / disarm
                    ep_take = ctrl_en;
                end else if (is_len) begin
                    if (!len_ok) begin
                        err_set = 1'b1;
                    end else begin
                        start_clr = 1'b1;
                        len_take  = 1'b1;
                        if (len_zero) begin
                            done_set = 1'b1;       // empty
                            done_len = '0;
                            state_d  = ST_IDLE;
                        end else begin
                            state_d  = ST_LOAD;    // start
                        end
                    end
                end else if (is_data) begin
                    if (state_q == ST_LOAD) begin
                        mem_we    = 1'b1;
                        word_take = 1'b1;
                        if (rem_after <= 0) begin
                            done_set = 1'b1;       // finish
                            state_d  = ST_IDLE;
                        end
                    end else begin
                        err_set = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Selection, length and word-slot tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ep_q   <= '0;
            len_q  <= '0;
            rem_q  <= '0;
            widx_q <= '0;
        end else begin
            if (ep_take) ep_q <= ctrl_ep;
            if (len_take) begin
                len_q  <= len_val;
                rem_q  <= $signed({1'b0, len_val});
                widx_q <= '0;
            end else if (word_take) begin
                rem_q  <= rem_after;
                widx_q <= WADDR_W'(widx_q + 1'b1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
    end

    assign cur_ep   = ep_q;
    assign cur_widx = widx_q;
    assign err_flag = err_q;

endmodule

// File: rtl/ldr_buf_mem.sv
module ldr_buf_mem
    import ldr_pkg::*;
#(
    parameter int NUM_EP        = 4,
    parameter int MAX_PKT_BYTES = 64,
    localparam int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int WORDS   = MAX_PKT_BYTES / WORD_BYTES,
    localparam int WADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BADDR_W = WADDR_W + 2
) (
    input  logic               clk,
    input  logic               we,
    input  logic [EP_W-1:0]    wr_ep,
    input  logic [WADDR_W-1:0] wr_widx,
    input  logic [31:0]        wr_word,
    input  logic [EP_W-1:0]    rd_ep,
    input  logic [BADDR_W-1:0] rd_idx,
    output logic [7:0]         rd_byte
);

    logic [31:0] ep_word [NUM_EP];

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep_buf
        logic [31:0] slots [WORDS];

        always_ff @(posedge clk) begin
            if (we && (wr_ep == EP_W'(g))) slots[wr_widx] <= wr_word;
        end

        assign ep_word[g] = slots[rd_idx[BADDR_W-1:2]];
    end

    logic [31:0] sel_word;
    assign sel_word = ep_word[rd_ep];

    always_comb begin
        unique case (rd_idx[1:0])
            2'd0: rd_byte = sel_word[7:0];
            2'd1: rd_byte = sel_word[15:8];
            2'd2: rd_byte = sel_word[23:16];
            default: rd_byte = sel_word[31:24];
        endcase
    end

endmodule

// File: rtl/ldr_ready_flags.sv
module ldr_ready_flags #(
    parameter int NUM_EP = 4,
    parameter int LEN_W  = 10,
    localparam int EP_W  = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic              start_clr,
    input  logic [EP_W-1:0]   cur_ep,
    input  logic [LEN_W-1:0]  set_len,
    input  logic              ack,
    input  logic [EP_W-1:0]   ack_ep,
    input  logic [EP_W-1:0]   rd_ep,
    output logic [NUM_EP-1:0] ready,
    output logic [LEN_W-1:0]  rd_count
);

    logic [LEN_W-1:0] count [NUM_EP];

    for (genvar g = 0; g < NUM_EP; g++) begin : g_flag
        logic hit_cur, hit_ack;
        assign hit_cur = (cur_ep == EP_W'(g));
        assign hit_ack = ack && (ack_ep == EP_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ready[g] <= 1'b0;
                count[g] <= '0;
            end else if (set_en && hit_cur) begin
                ready[g] <= 1'b1;          // completion outranks clears
                count[g] <= set_len;
            end else if ((start_clr && hit_cur) || hit_ack) begin
                ready[g] <= 1'b0;
            end
        end
    end

    assign rd_count = count[rd_ep];

endmodule

// File: rtl/ep_tx_loader.sv
module ep_tx_loader
    import ldr_pkg::*;
#(
    parameter int NUM_EP        = 4,
    parameter int MAX_PKT_BYTES = 64,
    parameter int LEN_W         = 10,
    localparam int EP_W    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
    localparam int WORDS   = MAX_PKT_BYTES / WORD_BYTES,
    localparam int WADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int BADDR_W = WADDR_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [1:0]         reg_sel,
    input  logic [31:0]        reg_wdata,
    input  logic               sie_ack,
    input  logic [EP_W-1:0]    sie_ack_ep,
    input  logic [EP_W-1:0]    sie_rd_ep,
    input  logic [BADDR_W-1:0] sie_rd_idx,
    output logic [NUM_EP-1:0]  pkt_ready,
    output logic [LEN_W-1:0]   sie_byte_count,
    output logic [7:0]         sie_rd_byte,
    output logic               load_err
);

    logic               mem_we;
    logic [EP_W-1:0]    cur_ep;
    logic [WADDR_W-1:0] cur_widx;
    logic               done_set;
    logic [LEN_W-1:0]   done_len;
    logic               start_clr;

    ldr_ctrl_fsm #(
        .NUM_EP(NUM_EP), .MAX_PKT_BYTES(MAX_PKT_BYTES), .LEN_W(LEN_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_we(mem_we), .cur_ep(cur_ep), .cur_widx(cur_widx),
        .done_set(done_set), .done_len(done_len),
        .start_clr(start_clr), .err_flag(load_err)
    );

    ldr_buf_mem #(
        .NUM_EP(NUM_EP), .MAX_PKT_BYTES(MAX_PKT_BYTES)
    ) mem_i (
        .clk(clk), .we(mem_we), .wr_ep(cur_ep), .wr_widx(cur_widx),
        .wr_word(reg_wdata), .rd_ep(sie_rd_ep), .rd_idx(sie_rd_idx),
        .rd_byte(sie_rd_byte)
    );

    ldr_ready_flags #(
        .NUM_EP(NUM_EP), .LEN_W(LEN_W)
    ) flags_i (
        .clk(clk), .rst_n(rst_n),
        .set_en(done_set), .start_clr(start_clr), .cur_ep(cur_ep),
        .set_len(done_len), .ack(sie_ack), .ack_ep(sie_ack_ep),
        .rd_ep(sie_rd_ep), .ready(pkt_ready), .rd_count(sie_byte_count)
    );

endmodule

// File: rtl/ep_tx_loader_chk.sv
module ep_tx_loader_chk #(
    parameter int NUM_EP        = 4,
    parameter int MAX_PKT_BYTES = 64,
    parameter int LEN_W         = 10,
    localparam int EP_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [1:0]        reg_sel,
    input logic [31:0]       reg_wdata,
    input logic              sie_ack,
    input logic [EP_W-1:0]   sie_ack_ep,
    input logic [NUM_EP-1:0] pkt_ready,
    input logic [LEN_W-1:0]  sie_byte_count,
    input logic              load_err
);

    assert_ctrl_no_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> ((pkt_ready & ~$past(pkt_ready)) == '0));

    assert_count_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, sie_byte_count} <= (LEN_W+1)'(MAX_PKT_BYTES)));

    assert_ready_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pkt_ready & ~$past(pkt_ready)) != '0) |->
            ($past(reg_wr) && ($past(reg_sel) == 2'd1 || $past(reg_sel) == 2'd2)));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_err |=> load_err);

    assert_bad_len_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 &&
         {1'b0, reg_wdata[LEN_W-1:0]} > (LEN_W+1)'(MAX_PKT_BYTES)) |=> load_err);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && sie_ack) |=> !pkt_ready[$past(sie_ack_ep)]);

endmodule

bind ep_tx_loader ep_tx_loader_chk #(
    .NUM_EP(NUM_EP), .MAX_PKT_BYTES(MAX_PKT_BYTES), .LEN_W(LEN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .sie_ack(sie_ack), .sie_ack_ep(sie_ack_ep),
    .pkt_ready(pkt_ready), .sie_byte_count(sie_byte_count), .load_err(load_err)
);

// File: tb/ep_tx_loader_tb_top.sv
`timescale 1ns/10ps
module ep_tx_loader_tb_top;

    localparam int NUM_EP  = 4;
    localparam int MAXB    = 64;
    localparam int LEN_W   = 10;
    localparam int EP_W    = 2;
    localparam int WORDS   = MAXB / 4;
    localparam int BADDR_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic sie_ack = 1'b0;
    logic [EP_W-1:0] sie_ack_ep = '0;
    logic [EP_W-1:0] sie_rd_ep = '0;
    logic [BADDR_W-1:0] sie_rd_idx = '0;
    logic [NUM_EP-1:0] pkt_ready;
    logic [LEN_W-1:0] sie_byte_count;
    logic [7:0] sie_rd_byte;
    logic load_err;

    always #2.5 clk = ~clk;

    ep_tx_loader #(.NUM_EP(NUM_EP), .MAX_PKT_BYTES(MAXB), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .sie_ack(sie_ack), .sie_ack_ep(sie_ack_ep),
        .sie_rd_ep(sie_rd_ep), .sie_rd_idx(sie_rd_idx), .pkt_ready(pkt_ready),
        .sie_byte_count(sie_byte_count), .sie_rd_byte(sie_rd_byte),
        .load_err(load_err)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model, built from the requirements
    bit m_armed, m_load, m_err;
    int m_ep, m_rem, m_idx, m_len;
    bit [31:0] m_mem [NUM_EP][WORDS];
    bit m_rdy [NUM_EP];
    int m_cnt [NUM_EP];

    function automatic bit [7:0] exp_byte(int ep, int b);
        return m_mem[ep][b / 4][8 * (b % 4) +: 8];
    endfunction

    function automatic bit [31:0] ctrl_word(bit en, int ep);
        return (32'(ep) << 1) | 32'(en);
    endfunction

    task automatic model_reset();
        m_armed = 0; m_load = 0; m_err = 0; m_ep = 0; m_rem = 0; m_idx = 0; m_len = 0;
        for (int e = 0; e < NUM_EP; e++) begin m_rdy[e] = 0; m_cnt[e] = 0; end
    endtask

    task automatic model_apply(bit wr, int sel, bit [31:0] d, bit ack, int aep);
        int len;
        if (ack) m_rdy[aep] = 0;
        if (!wr) return;
        case (sel)
            0: begin
                if (d[0]) begin m_ep = int'(d[EP_W:1]); m_armed = 1; end
                else m_armed = 0;
                m_load = 0;
            end
            1: begin
                len = int'(d[LEN_W-1:0]);
                if (!m_armed || len > MAXB) m_err = 1;
                else begin
                    m_rdy[m_ep] = 0;
                    if (len == 0) begin
                        m_rdy[m_ep] = 1; m_cnt[m_ep] = 0; m_armed = 0; m_load = 0;
                    end else begin
                        m_load = 1; m_rem = len; m_idx = 0; m_len = len;
                    end
                end
            end
            2: begin
                if (!m_load) m_err = 1;
                else begin
                    m_mem[m_ep][m_idx] = d;
                    m_idx++; m_rem -= 4;
                    if (m_rem <= 0) begin
                        m_rdy[m_ep] = 1; m_cnt[m_ep] = m_len; m_armed = 0; m_load = 0;
                    end
                end
            end
            default: ;
        endcase
    endtask

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called just after a falling edge; finishes in well under half a period
    task automatic check_all(string tag);
        for (int e = 0; e < NUM_EP; e++) begin
            chk(tag, longint'(pkt_ready[e]), longint'(m_rdy[e]));
            sie_rd_ep = EP_W'(e);
            #0.1;
            chk(tag, longint'(sie_byte_count), longint'(m_cnt[e]));
        end
        chk(tag, longint'(load_err), longint'(m_err));
    endtask

    task automatic check_bytes(string tag, int ep, int nbytes);
        sie_rd_ep = EP_W'(ep);
        for (int b = 0; b < nbytes; b++) begin
            sie_rd_idx = BADDR_W'(b);
            #0.1;
            chk(tag, longint'(sie_rd_byte), longint'(exp_byte(ep, b)));
        end
        @(negedge clk);
    endtask

    task automatic cyc(bit wr, int sel, bit [31:0] d, bit ack, int aep);
        reg_wr = wr; reg_sel = 2'(sel); reg_wdata = d;
        sie_ack = ack; sie_ack_ep = EP_W'(aep);
        @(posedge clk);
        model_apply(wr, sel, d, ack, aep);
        @(negedge clk);
        reg_wr = 0; sie_ack = 0;
    endtask

    task automatic wr_reg(int sel, bit [31:0] d);
        cyc(1, sel, d, 0, 0);
    endtask

    task automatic do_reset();
        rst_n = 0; reg_wr = 0; sie_ack = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        r = $urandom(32'h5EED_0042);
        do_reset();
        check_all("R10 reset state");

        // R3/R4: five bytes in two words on endpoint 1
        wr_reg(0, ctrl_word(1, 1));
        check_all("R1 arm ep1 no ready");
        wr_reg(1, 32'd5);
        wr_reg(2, 32'h4433_2211);
        chk("R4 not ready after first word", longint'(pkt_ready[1]), 0);
        wr_reg(2, 32'h0000_00AA);
        check_all("R4 ready count 5 after second word");
        check_bytes("R3 little-endian bytes ep1", 1, 5);
        // R6: write after completion is ignored
        wr_reg(2, 32'hDEAD_BEEF);
        check_all("R6 data after finish sets err");
        check_bytes("R6 buffer unchanged", 1, 5);

        // R7: oversize length then valid
        do_reset();
        wr_reg(1, 32'd8);
        check_all("R7 length while idle");
        do_reset();
        wr_reg(0, ctrl_word(1, 2));
        wr_reg(1, 32'd100);
        check_all("R7 oversize length ignored");
        wr_reg(1, 32'd8);
        wr_reg(2, 32'h0807_0605);
        wr_reg(2, 32'h0C0B_0A09);
        check_all("R7 still armed after bad length");
        check_bytes("R3 bytes ep2", 2, 8);

        // R5: zero-length packet
        wr_reg(0, ctrl_word(1, 3));
        wr_reg(1, 32'd0);
        check_all("R5 zero length ready at once");

        // R8/R2/R11: ready set, restart clears, collide with ack
        wr_reg(0, ctrl_word(1, 0));
        wr_reg(1, 32'd4);
        wr_reg(2, 32'h1111_1111);
        wr_reg(0, ctrl_word(1, 0));
        wr_reg(1, 32'd4);
        check_all("R2 accepted length clears ready");
        cyc(1, 2, 32'h2222_2222, 1, 0);
        check_all("R8 finish and ack same ep set wins");
        cyc(0, 0, 0, 1, 0);
        check_all("R8 ack alone clears");
        wr_reg(0, ctrl_word(1, 1));
        wr_reg(1, 32'd4);
        cyc(1, 2, 32'h3333_3333, 1, 3);
        check_all("R11 finish ep1 ack ep3 same cycle");

        // R9: abandon mid-packet
        do_reset();
        wr_reg(0, ctrl_word(1, 1));
        wr_reg(1, 32'd12);
        wr_reg(2, 32'h0A0A_0A0A);
        wr_reg(0, ctrl_word(0, 1));
        wr_reg(2, 32'h0B0B_0B0B);
        check_all("R9 abandoned packet no ready");

        // R4: split 130 bytes into 64, 64, 2
        do_reset();
        for (int p = 0; p < 3; p++) begin
            int n;
            n = (p < 2) ? 64 : 2;
            if (p > 0) cyc(0, 0, 0, 1, 2);
            wr_reg(0, ctrl_word(1, 2));
            wr_reg(1, 32'(n));
            for (int w = 0; w < (n + 3) / 4; w++) wr_reg(2, $urandom);
            check_all("R4 split packet count");
            check_bytes("R3 split packet bytes", 2, n);
        end

        // random phase
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            int pick, sel;
            bit [31:0] d;
            bit ack;
            pick = int'($urandom % 100);
            ack = ($urandom % 5) == 0;
            if (m_load) sel = (pick < 75) ? 2 : (pick < 85) ? 1 : (pick < 95) ? 0 : 3;
            else        sel = (pick < 40) ? 0 : (pick < 80) ? 1 : (pick < 95) ? 2 : 3;
            case (sel)
                0: d = ctrl_word(($urandom % 8) != 0, int'($urandom % NUM_EP));
                1: d = (($urandom % 8) != 0) ? 32'($urandom % (MAXB + 1))
                                             : 32'(MAXB + 1 + ($urandom % 900));
                default: d = $urandom;
            endcase
            cyc(($urandom % 6) != 0, sel, d, ack, int'($urandom % NUM_EP));
            check_all("R11 random traffic");
            if (i % 97 == 0)
                for (int e = 0; e < NUM_EP; e++)
                    if (m_rdy[e]) check_bytes("R3 random bytes", e, m_cnt[e]);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule